// File: doc/BRIEF.md
# Interprocessor Interrupt Command Dispatcher

This block takes one 64-bit interprocessor interrupt command at a time from a sending CPU and turns it into per-CPU actions for a small multiprocessor of up to eight CPUs. Fixed and non-maskable commands are expanded from a destination shorthand into a set of target CPUs. The block then hands out one delivery per cycle, starting at the lowest CPU index. Each delivery carries either the vector or an NMI flag.

The block also tracks how each CPU comes up. Every CPU other than CPU 0 starts out held in reset. An INIT command from CPU 0 arms such a CPU to wait for a startup command. A later startup command releases it, which produces a single start request whose address comes from the vector. The released CPU then counts as active, and shorthands that address "all CPUs" include it from then on. Commands the block cannot act on raise a one-cycle unhandled strobe, so that a slower path can deal with them.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset `cmd_ready` is 1, there are no deliveries, strobes or start requests, `cpu_running` is 1 only for CPU 0, and `boot_wait` is all zero. CPU 0 stays running at all times.
- R2: With `ext_mode`=0 the destination is `cmd_word[63:56]`. With `ext_mode`=1 it is the full `cmd_word[63:32]`. A destination of NCPU or more matches no CPU.
- R3: The mode field is `cmd_word[10:8]`. For fixed (000) and NMI (100) commands, the shorthand `cmd_word[19:18]` selects the target set: 00 = the destination CPU, 01 = the sender only, 10 = all running CPUs, 11 = all running CPUs except the sender.
- R4: Every delivery of a fixed command carries `dlv_vector` = `cmd_word[7:0]` with `dlv_nmi`=0. Every delivery of an NMI command has `dlv_nmi`=1.
- R5: Deliveries appear one per cycle from the cycle after acceptance, in strictly ascending CPU order. `cmd_ready` stays low until the last delivery has gone out. An empty set produces no delivery.
- R6: An INIT command (101) with its level bit `cmd_word[14]` at 0 (deassert) has no effect on any state and raises no strobe.
- R7: An INIT command with the level bit at 1, sent by CPU 0 to a destination in 1..NCPU-1, moves that CPU from held to waiting. A target that is already waiting or running is left unchanged.
- R8: A startup command (110) from CPU 0 to a waiting CPU in 1..NCPU-1 raises `start_valid` for one cycle in the cycle after acceptance, with `start_cpu` set to the destination and `start_addr` = vector shifted left by 12. The target becomes running and is included in later all-CPU shorthands.
- R9: A startup command from CPU 0 to a valid destination that is not waiting is dropped silently: no start request, no strobe, no state change.
- R10: `unhandled` pulses for one cycle after acceptance for any mode other than 000/100/101/110, and for an asserting INIT or a startup command whose sender is not CPU 0 or whose destination is 0 or at least NCPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command (no deliveries pending) |
| cmd_word | input | 64 | Interprocessor interrupt command word |
| cmd_sender | input | IW | Index of the sending CPU |
| ext_mode | input | 1 | 1 selects the 32-bit destination field |
| dlv_valid | output | 1 | A delivery is presented this cycle |
| dlv_cpu | output | IW | Target CPU of the delivery |
| dlv_nmi | output | 1 | Delivery is an NMI |
| dlv_vector | output | 8 | Vector of a fixed delivery |
| start_valid | output | 1 | One-cycle start request |
| start_cpu | output | IW | CPU being started |
| start_addr | output | 20 | Start address (vector << 12) |
| unhandled | output | 1 | One-cycle strobe for a command not handled |
| cpu_running | output | NCPU | Per-CPU running (active) flags |
| boot_wait | output | NCPU | Per-CPU waiting-for-startup flags |

## Verification
The fixed and NMI paths are swept across every shorthand, every sender and destinations from 0 to NCPU+1. The sweep runs once while only CPU 0 is active and again after several CPUs have been started, so the two all-CPU shorthands are compared against different active sets and the destination shorthand is compared with and without out-of-range values. The boot path is driven through a fixed script that covers deasserting INIT, wrong senders, destination 0 and out-of-range destinations, startup to held, waiting and running targets, and repeated INIT. Each step shows whether a transition was taken, dropped or reported as unhandled. The destination is placed differently in legacy and extended words: one word carries different values in bits 55:32 and 63:56, and another puts a high extended destination where its top byte reads as a valid CPU in legacy form. This shows which field was decoded.

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
  parameter int NCPU = 8,
  localparam int IW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [63:0]     cmd_word,
  input  logic [IW-1:0]   cmd_sender,
  input  logic            ext_mode,
  output logic            dlv_valid,
  output logic [IW-1:0]   dlv_cpu,
  output logic            dlv_nmi,
  output logic [7:0]      dlv_vector,
  output logic            start_valid,
  output logic [IW-1:0]   start_cpu,
  output logic [19:0]     start_addr,
  output logic            unhandled,
  output logic [NCPU-1:0] cpu_running,
  output logic [NCPU-1:0] boot_wait
);

  localparam logic [2:0] MD_FIXED = 3'b000;
  localparam logic [2:0] MD_NMI   = 3'b100;
  localparam logic [2:0] MD_INIT  = 3'b101;
  localparam logic [2:0] MD_START = 3'b110;

  logic [NCPU-1:0] run_q, wait_q, pend_q, set_c;
  logic [7:0]      vec_q;
  logic            nmi_q, unh_q, st_q;
  logic [IW-1:0]   st_cpu_q, low;
  logic [19:0]     st_addr_q;

  wire [31:0]   dest   = ext_mode ? cmd_word[63:32] : {24'd0, cmd_word[63:56]};
  wire [2:0]    mode   = cmd_word[10:8];
  wire [1:0]    shand  = cmd_word[19:18];
  wire          lvl    = cmd_word[14];
  wire [7:0]    vec    = cmd_word[7:0];
  wire          dest_ok = dest < 32'(NCPU);
  wire [IW-1:0] didx   = dest[IW-1:0];
  wire          boot_ok = (cmd_sender == '0) && (dest != 32'd0) && dest_ok;
  wire          accept = cmd_valid && cmd_ready;

  logic unused_bits;
  assign unused_bits = ^{cmd_word[31:20], cmd_word[17:15], cmd_word[13:11]};

  always_comb begin
    case (shand)
      2'b00:   set_c = dest_ok ? (NCPU'(1) << didx) : '0;
      2'b01:   set_c = NCPU'(1) << cmd_sender;
      2'b10:   set_c = run_q;
      default: set_c = run_q & ~(NCPU'(1) << cmd_sender);
    endcase
  end

  always_comb begin
    low = '0;
    for (int i = NCPU - 1; i >= 0; i--)
      if (pend_q[i]) low = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= NCPU'(1);
      wait_q    <= '0;
      pend_q    <= '0;
      vec_q     <= '0;
      nmi_q     <= 1'b0;
      unh_q     <= 1'b0;
      st_q      <= 1'b0;
      st_cpu_q  <= '0;
      st_addr_q <= '0;
    end else begin
      unh_q <= 1'b0;
      st_q  <= 1'b0;
      if (|pend_q) pend_q <= pend_q & ~(NCPU'(1) << low);
      if (accept) begin
        case (mode)
          MD_FIXED, MD_NMI: begin
            pend_q <= set_c;
            vec_q  <= vec;
            nmi_q  <= (mode == MD_NMI);
          end
          MD_INIT: begin
            if (lvl) begin
              if (!boot_ok) unh_q <= 1'b1;
              else if (!run_q[didx] && !wait_q[didx]) wait_q[didx] <= 1'b1;
            end
          end
          MD_START: begin
            if (!boot_ok) unh_q <= 1'b1;
            else if (wait_q[didx]) begin
              wait_q[didx] <= 1'b0;
              run_q[didx]  <= 1'b1;
              st_q         <= 1'b1;
              st_cpu_q     <= didx;
              st_addr_q    <= {vec, 12'h000};
            end
          end
          default: unh_q <= 1'b1;
        endcase
      end
    end
  end

  assign cmd_ready   = ~|pend_q;
  assign dlv_valid   = |pend_q;
  assign dlv_cpu     = low;
  assign dlv_nmi     = nmi_q;
  assign dlv_vector  = vec_q;
  assign start_valid = st_q;
  assign start_cpu   = st_cpu_q;
  assign start_addr  = st_addr_q;
  assign unhandled   = unh_q;
  assign cpu_running = run_q;
  assign boot_wait   = wait_q;

  AST_CPU0_RUNS: assert property (@(posedge clk) disable iff (!rst_n) cpu_running[0]); // R1
  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (cpu_running & boot_wait) == '0); // R7
  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> $countones(pend_q) == $countones($past(pend_q)) - 1); // R5
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && $past(dlv_valid) |-> dlv_cpu > $past(dlv_cpu)); // R5
  AST_START_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> cpu_running[start_cpu] && ((($past(boot_wait) >> start_cpu) & NCPU'(1)) != '0)); // R8
  AST_UNH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    unhandled |-> !start_valid && !dlv_valid); // R10

endmodule

// File: tb/sim_ipi_dispatch.sv
module sim_ipi_dispatch;
  localparam int NCPU = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, ext_mode, dlv_valid, dlv_nmi, start_valid, unhandled;
  logic [63:0] cmd_word;
  logic [IW-1:0] cmd_sender, dlv_cpu, start_cpu;
  logic [7:0] dlv_vector;
  logic [19:0] start_addr;
  logic [NCPU-1:0] cpu_running, boot_wait;

  ipi_dispatch #(.NCPU(NCPU)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_sender(cmd_sender), .ext_mode(ext_mode),
    .dlv_valid(dlv_valid), .dlv_cpu(dlv_cpu), .dlv_nmi(dlv_nmi), .dlv_vector(dlv_vector),
    .start_valid(start_valid), .start_cpu(start_cpu), .start_addr(start_addr),
    .unhandled(unhandled), .cpu_running(cpu_running), .boot_wait(boot_wait));

  int n_run = 0, n_fail = 0;
  logic [NCPU-1:0] m_run, m_wait;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] md, input logic [1:0] sh,
                                     input logic lv, input logic [7:0] v, input logic [31:0] d, input bit ext);
    logic [63:0] w = '0;
    if (ext) w[63:32] = d; else w[63:56] = d[7:0];
    w[19:18] = sh; w[14] = lv; w[10:8] = md; w[7:0] = v;
    return w;
  endfunction

  task automatic issue(input logic [63:0] w, input int snd, input bit ext, input string req);
    logic [31:0] d = ext ? w[63:32] : {24'd0, w[63:56]};
    logic [2:0] md = w[10:8];
    logic [7:0] v = w[7:0];
    bit ok_d = d < NCPU;
    bit boot = (snd == 0) && (d != 0) && ok_d;
    logic [NCPU-1:0] exp_mask = '0, got = '0;
    bit exp_unh = 0, exp_st = 0, ordered = 1;
    int prev = -1, guard = 0;
    if (md == 3'b000 || md == 3'b100) begin
      case (w[19:18])
        2'b00: exp_mask = ok_d ? NCPU'(1) << d : '0;
        2'b01: exp_mask = NCPU'(1) << snd;
        2'b10: exp_mask = m_run;
        default: exp_mask = m_run & ~(NCPU'(1) << snd);
      endcase
    end else if (md == 3'b101) begin
      if (w[14]) begin
        if (!boot) exp_unh = 1;
        else if (!m_run[d] && !m_wait[d]) m_wait[d] = 1'b1;
      end
    end else if (md == 3'b110) begin
      if (!boot) exp_unh = 1;
      else if (m_wait[d]) begin
        m_wait[d] = 1'b0; m_run[d] = 1'b1; exp_st = 1;
      end
    end else exp_unh = 1;

    @(negedge clk);
    cmd_word = w; cmd_sender = IW'(snd); ext_mode = ext; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R5", "ready when idle", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(unhandled == exp_unh, exp_unh ? "R10" : req, "unhandled", unhandled, exp_unh);
    chk(start_valid == exp_st, exp_st ? "R8" : req, "start_valid", start_valid, exp_st);
    if (exp_st) begin
      chk(start_cpu == d[IW-1:0], "R8", "start_cpu", start_cpu, d);
      chk(start_addr == {v, 12'h000}, "R8", "start_addr", start_addr, {v, 12'h000});
    end
    while (dlv_valid && guard < 2 * NCPU) begin
      guard++;
      chk(cmd_ready == 1'b0, "R5", "ready while busy", cmd_ready, 0);
      chk(dlv_nmi == (md == 3'b100), "R4", "dlv_nmi", dlv_nmi, md == 3'b100);
      if (md == 3'b000) chk(dlv_vector == v, "R4", "dlv_vector", dlv_vector, v);
      if (int'(dlv_cpu) <= prev) ordered = 0;
      got[dlv_cpu] = 1'b1;
      prev = int'(dlv_cpu);
      @(negedge clk);
    end
    chk(got == exp_mask, "R3", "delivery set", got, exp_mask);
    chk(ordered, "R5", "ascending order", ordered, 1);
    chk(cpu_running == m_run, req, "cpu_running", cpu_running, m_run);
    chk(boot_wait == m_wait, req, "boot_wait", boot_wait, m_wait);
  endtask

  task automatic sweep(input int sh_lo);
    for (int md = 0; md < 2; md++)
      for (int sh = sh_lo; sh < 4; sh++)
        for (int s = 0; s < NCPU; s++)
          for (int d = 0; d < NCPU + 2; d++)
            issue(mk(md ? 3'b100 : 3'b000, 2'(sh), 1'b1, 8'(32 + d * 7 + s), 32'(d), 0), s, 0, "R3");
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0; cmd_sender = '0; ext_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    chk(dlv_valid == 1'b0, "R1", "no delivery after reset", dlv_valid, 0);
    chk(unhandled == 1'b0 && start_valid == 1'b0, "R1", "strobes after reset", {unhandled, start_valid}, 0);
    chk(cpu_running == NCPU'(1), "R1", "running after reset", cpu_running, 1);
    chk(boot_wait == '0, "R1", "waiting after reset", boot_wait, 0);
    m_run = NCPU'(1); m_wait = '0;

    sweep(0);

    issue(mk(3'b101, 2'b00, 1'b0, 8'h00, 32'd3, 0), 0, 0, "R6");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd3, 0), 2, 0, "R10");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd0, 0), 0, 0, "R10");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd8, 0), 0, 0, "R10");
    issue(mk(3'b110, 2'b00, 1'b1, 8'h40, 32'd3, 0), 0, 0, "R9");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd3, 0), 0, 0, "R7");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd5, 0), 0, 0, "R7");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd7, 0), 0, 0, "R7");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd3, 0), 0, 0, "R7");
    issue(mk(3'b101, 2'b00, 1'b0, 8'h00, 32'd7, 0), 0, 0, "R6");
    issue(mk(3'b110, 2'b00, 1'b1, 8'h9A, 32'd3, 0), 1, 0, "R10");
    issue(mk(3'b110, 2'b00, 1'b1, 8'h9A, 32'd3, 0), 0, 0, "R8");
    issue(mk(3'b110, 2'b00, 1'b1, 8'h9B, 32'd3, 0), 0, 0, "R9");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd3, 0), 0, 0, "R7");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'd6, 1), 0, 1, "R2");
    issue(mk(3'b110, 2'b00, 1'b1, 8'h10, 32'd6, 1), 0, 1, "R2");
    issue(mk(3'b101, 2'b00, 1'b1, 8'h00, 32'h0100_0001, 1), 0, 1, "R2");
    issue(mk(3'b110, 2'b00, 1'b1, 8'hFF, 32'd5, 0) | 64'h0000_0002_0000_0000, 0, 0, "R2");
    issue(mk(3'b000, 2'b00, 1'b1, 8'h21, 32'd2, 1) | 64'h0400_0000_0000_0000, 0, 1, "R2");
    for (int md = 1; md < 8; md++)
      if (md != 4 && md != 5 && md != 6)
        issue(mk(3'(md), 2'b00, 1'b1, 8'h33, 32'd1, 0), 0, 0, "R10");

    sweep(2);

    summary();
    $finish;
  end
endmodule